// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block counts system clock cycles from the last restart. When the selected interval runs out it raises a sticky timeout flag, and raises an interrupt line while that flag is set and interrupts are enabled. A second stage then opens a fixed grace window of 512 cycles. If software does not restart the watchdog before that window closes, and reset is enabled, the block emits a one-cycle reset request for the chip's reset logic to act on.

The interval length comes from two 2-bit selections, a range code and a divide code. Together they give 2^(12 + 3·range + divide) cycles, so the interval runs from 2^12 to 2^24 cycles. The interval counter wraps at expiry and starts a new interval on its own. Software restarts the watchdog with a strobe and clears the flag with a separate strobe.

Top module: `wdt_two_stage`

## Requirements
- R1: While reset is asserted and right after it, the flag, the interrupt and the reset request are all 0.
- R2: The flag rises exactly 2^(12 + 3·wd_sel + cd_sel) clock edges after the edge that samples `restart` high. wd_sel and cd_sel are read as unsigned values from 0 to 3.
- R3: `wd_irq` is high whenever the flag is set and `irq_en` is 1. It stays low while `irq_en` is 0, even when the flag is set.
- R4: Once set, the flag stays set until `flag_clr` is sampled high. A restart leaves it unchanged.
- R5: When `rst_en` is 1 at expiry, `wd_rst_req` is high for exactly one cycle, 512 edges after the expiry edge, provided no restart comes in between.
- R6: A restart sampled inside the 512-cycle grace window cancels the pending reset request.
- R7: With `rst_en` at 0, no reset request is issued. The counter wraps at expiry, and the next expiry comes one full interval later.
- R8: Restarts issued before the interval runs out prevent any expiry, and each one begins a fresh full interval.
- R9: A `flag_clr` sampled high clears the flag on that edge, unless an expiry happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wd_sel | input | 2 | Interval range code, adds 3 to the exponent per step |
| cd_sel | input | 2 | Divide code, adds 1 to the exponent per step |
| irq_en | input | 1 | Interrupt enable |
| rst_en | input | 1 | Reset request enable |
| restart | input | 1 | Restart strobe: clears the counter and cancels the grace window |
| flag_clr | input | 1 | Clears the timeout flag |
| wd_irq | output | 1 | Timeout interrupt |
| wd_flag | output | 1 | Sticky timeout flag |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
Every timed result is counted from the edge that samples a restart. The flag is due after exactly 2^(12+3·wd_sel+cd_sel) edges, and the reset request 512 edges after that. The interrupt follows the flag in the same cycle, because it is combinational. The driver records the edge index of each restart and pushes the exact cycle and kind of every event it expects into a queue. The monitor samples on the falling edge, tags each flag rise and each reset-request cycle with the current edge count, and compares it with the head of that queue. Any early, late, missing or extra event therefore shows up as a mismatch.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int BASE_EXP = 12,
  parameter int GRACE    = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wd_sel,
  input  logic [1:0] cd_sel,
  input  logic       irq_en,
  input  logic       rst_en,
  input  logic       restart,
  input  logic       flag_clr,
  output logic       wd_irq,
  output logic       wd_flag,
  output logic       wd_rst_req
);
  localparam int SPAN = 12;
  localparam int CW   = BASE_EXP + SPAN;
  localparam int GW   = $clog2(GRACE);

  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic          gact, flag_q, rreq_q;
  logic [4:0]    step;
  logic [CW-1:0] lim_m1;
  logic          expire, g_end;

  assign step   = 5'(wd_sel) * 5'd3 + 5'(cd_sel);
  assign lim_m1 = {CW{1'b1}} >> (5'(SPAN) - step);
  assign expire = !restart && (cnt >= lim_m1);
  assign g_end  = gact && (gcnt == GW'(GRACE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || expire) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gact <= 1'b0;
      gcnt <= '0;
    end else if (restart) begin
      gact <= 1'b0;
    end else if (expire) begin
      gact <= rst_en;
      gcnt <= '0;
    end else if (g_end) begin
      gact <= 1'b0;
    end else if (gact) begin
      gcnt <= gcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rreq_q <= 1'b0;
    else        rreq_q <= !restart && g_end && rst_en;
  end

  assign wd_flag    = flag_q;
  assign wd_irq     = flag_q & irq_en;
  assign wd_rst_req = rreq_q;

  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);
  p_restart_cancels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !wd_rst_req);
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !flag_clr) |=> wd_flag);
  p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_flag) |-> $past(flag_clr));
  p_no_rise_on_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> !$past(restart));
  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_en && !gact) |=> !wd_rst_req);
endmodule

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] wd_sel = 2'd0, cd_sel = 2'd0;
  logic irq_en = 1'b0, rst_en = 1'b0, restart = 1'b0, flag_clr = 1'b0;
  logic wd_irq, wd_flag, wd_rst_req;
  int cyc = 0, checks = 0, fails = 0, rc = 0;
  int expq[$];
  logic prev_flag = 1'b0;
  bit done = 1'b0;

  wdt_two_stage uut (.clk(clk), .rst_n(rst_n), .wd_sel(wd_sel), .cd_sel(cd_sel),
    .irq_en(irq_en), .rst_en(rst_en), .restart(restart), .flag_clr(flag_clr),
    .wd_irq(wd_irq), .wd_flag(wd_flag), .wd_rst_req(wd_rst_req));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: each event is cycle*2+kind, kind 0 = flag rise (R2), 1 = reset request (R5)
  task automatic event_seen(input int code);
    if (expq.size() == 0) check(1'b0, (code % 2) ? "R5/R6/R7 unexpected reset request" : "R2 unexpected flag rise", code / 2, -1);
    else begin
      int e;
      e = expq.pop_front();
      check(e == code, (e % 2) ? "R5 reset request timing" : "R2 flag rise timing", code, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wd_flag && !prev_flag) event_seen(cyc * 2);
      if (wd_rst_req) event_seen(cyc * 2 + 1);
    end
    prev_flag <= wd_flag;
  end

  task automatic start(input int w, input int c, input bit ie, input bit re);
    @(negedge clk);
    wd_sel = 2'(w); cd_sel = 2'(c); irq_en = ie; rst_en = re;
    restart = 1'b1; flag_clr = 1'b1;
    rc = cyc + 1;
    @(negedge clk);
    restart = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart = 1'b1; rc = cyc + 1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_ev(input int c, input int kind);
    expq.push_back(c * 2 + kind);
  endtask

  initial begin
    int l;
    repeat (3) @(negedge clk);
    check(wd_flag == 0 && wd_irq == 0 && wd_rst_req == 0, "R1 outputs in reset", {wd_flag, wd_irq, wd_rst_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wd_flag == 0 && wd_irq == 0 && wd_rst_req == 0, "R1 outputs after reset", {wd_flag, wd_irq, wd_rst_req}, 0);

    // R2 R5 R3: shortest interval, reset enabled
    start(0, 0, 1'b1, 1'b1);
    l = 4096;
    expect_ev(rc + l, 0); expect_ev(rc + l + 512, 1);
    wait_to(rc + l - 1);
    check(wd_irq == 0, "R3 irq before expiry", wd_irq, 0);
    wait_to(rc + l + 20);
    check(wd_irq == 1, "R3 irq with flag and enable", wd_irq, 1);
    wait_to(rc + l + 520);

    // R6 R4: restart inside grace window
    start(0, 1, 1'b1, 1'b1);
    l = 8192;
    expect_ev(rc + l, 0);
    wait_to(rc + l + 300);
    pulse_restart();
    @(negedge clk);
    check(wd_flag == 1, "R4 flag kept across restart", wd_flag, 1);
    wait_to(cyc + 800);
    check(wd_flag == 1, "R4 flag still set", wd_flag, 1);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(wd_flag == 0, "R9 flag cleared", wd_flag, 0);

    // R7 R3: reset disabled, irq disabled, rollover
    start(1, 0, 1'b0, 1'b0);
    l = 32768;
    expect_ev(rc + l, 0); expect_ev(rc + 2 * l, 0);
    wait_to(rc + l + 50);
    check(wd_flag == 1 && wd_irq == 0, "R3 irq masked while flag set", wd_irq, 0);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(wd_flag == 0, "R9 flag cleared before rollover", wd_flag, 0);
    wait_to(rc + 2 * l + 600);
    check(wd_flag == 1, "R7 second expiry after rollover", wd_flag, 1);

    // R2 R5: divide code 2
    start(0, 2, 1'b1, 1'b1);
    l = 16384;
    expect_ev(rc + l, 0); expect_ev(rc + l + 512, 1);
    wait_to(rc + l + 530);

    // R8: timely restarts hold off expiry
    start(0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      wait_to(rc + 4000);
      pulse_restart();
    end
    check(wd_flag == 0, "R8 no expiry with timely restarts", wd_flag, 0);
    expect_ev(rc + 4096, 0); expect_ev(rc + 4096 + 512, 1);
    wait_to(rc + 4096 + 530);
    pulse_restart();
    wait_to(cyc + 20);
    check(expq.size() == 0, "R2/R5 all expected events seen", expq.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule